// File: doc/BRIEF.md
# Multiplexed Host Port Bridge

This block is a slave port that gives an external host access to an internal word-addressed memory over a single 16-bit bus. Read data and write data share that bus, and the read/write line sets the direction. The host frames each access with a chip select and a data strobe. A 2-bit control field picks the target of the access: the configuration register, the address register, a data word with no change to the address, or a data word after which the address advances. Two active-low byte enables allow the host to move single bytes. An optional active-low address strobe latches the control field and the direction ahead of the data phase.

All host inputs are brought into the internal clock domain through two-stage synchronisers. The qualified strobe is active only while chip select and data strobe are both low, and its start is edge-detected. Each strobe starts exactly one transfer. A data transfer drives one single-cycle request into a synchronous memory port that returns read data one cycle later. The ready output shows the internal ready flag: it is low while a memory transfer is in progress and high once the transfer finishes. The block keeps a base address, which is what host reads of the address register return, and a separate working pointer that auto-increment moves forward.

Top module: `hostport_bridge`

## Requirements
- R1: The qualified strobe is the AND of chip select low and data strobe low. Each strobe produces exactly one memory request pulse for a data access and none for a register access. This holds even when the data strobe is held low permanently and chip select alone frames each access.
- R2: Control value 2'b11 reads or writes the word at the working pointer and leaves the pointer unchanged.
- R3: Control value 2'b01 reads or writes the word at the working pointer and then adds one to the pointer, so successive accesses reach n, n+1, n+2.
- R4: A host read of the address register (control 2'b10) returns the base address last written, even after auto-increment has moved the working pointer.
- R5: The byte enables are active low, and bit 1 is the high byte of the host bus. They map to the memory lane enables as mem_be = ~host_be_n. In auto-increment mode the pointer advances only when host_be_n[1] is 0. An access with only the low byte enabled leaves the pointer unchanged.
- R6: host_rdy is 1 after reset. It is 0 while a memory request is outstanding and returns to 1 when the transfer completes, before the strobe ends.
- R7: host_d_oe is 1 only while the qualified strobe is active during a read whose data is ready. At all other times it is 0. While host_d_oe is 1, host_d_out holds the result of the read.
- R8: Control 2'b10 with host_rw=0 loads the base address and the working pointer from host_d_in. Control 2'b00 reaches the configuration register: bit 0 is the byte-swap flag and reads back in bit 0. When the flag is 1, data transfers exchange the two bytes of the data word and the two lane enables.
- R9: On a falling edge of host_as_n, the control field and host_rw are latched, and the next strobe uses the latched values even if those pins change afterwards. When host_as_n is held high, the pins are sampled at the start of the strobe.
- R10: After reset, host_d_oe is 0, mem_req is 0, the base address and working pointer are 0, and the byte-swap flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ds_n | input | 1 | Host data strobe, active low |
| host_as_n | input | 1 | Host address strobe, active low, latches control and direction |
| host_rw | input | 1 | 1 = host reads, 0 = host writes |
| host_ctl | input | 2 | Access target: 00 config, 01 data auto-increment, 10 address, 11 data fixed |
| host_be_n | input | 2 | Byte enables, active low, bit 1 = high byte |
| host_d_in | input | 16 | Data from host |
| host_d_out | output | 16 | Data to host |
| host_d_oe | output | 1 | Output enable for host_d_out |
| host_rdy | output | 1 | Ready, high when no transfer is in progress |
| mem_req | output | 1 | Single-cycle memory request |
| mem_we | output | 1 | Memory write enable, qualifies mem_req |
| mem_addr | output | 16 | Memory word address |
| mem_be | output | 2 | Memory lane enables, active high |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read request |

## Verification
The hardest states to reach are those where the pointer the host can see differs from the pointer in use. Two cases matter: after a run of auto-increment writes, and after a mixed run of byte-only accesses. To reach them, the stimulus loads an address and issues three full-word auto-increment writes, then reads the address register. It then walks one word with a low-byte access followed by a high-byte access and reads the merged word back in fixed mode. Latching through the address strobe is tested by changing the control and direction pins between the strobe edge and the data phase. The data strobe is also tied low for a run in which chip select alone frames each access.

// File: rtl/hpi_pkg.sv
// Shared types for the host port bridge.
// Assumes: a two-bit control field whose encodings the host driver also uses.
package hpi_pkg;
    typedef enum logic [1:0] {
        CTL_CFG   = 2'b00,
        CTL_AUTO  = 2'b01,
        CTL_ADDR  = 2'b10,
        CTL_FIXED = 2'b11
    } ctl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_CAPT  = 2'b10,
        ST_HOLD  = 2'b11
    } state_e;
endpackage

// File: rtl/hpi_sync.sv
// Two-stage synchroniser bank for the asynchronous host inputs.
// Assumes: each bit is treated independently; multi-bit fields are held stable
// by the host for several clocks around the strobe, so skew between bits settles.
module hpi_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            logic s1, s2;
            // Two flops per bit; reset to the idle (high) level of the strobes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b1;
                    s2 <= 1'b1;
                end else begin
                    s1 <= d[i];
                    s2 <= s1;
                end
            end
            assign q[i] = s2;
        end
    endgenerate
endmodule

// File: rtl/hpi_strobe.sv
// Strobe qualification and control capture.
// Produces the qualified strobe (chip select AND data strobe, both low), a
// one-cycle start pulse, and the control/direction used by this access: the
// values latched at the last address-strobe fall, or the live pins otherwise.
// Assumes: all inputs are already synchronised.
module hpi_strobe
    import hpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_s,
    input  logic       ds_n_s,
    input  logic       as_n_s,
    input  logic [1:0] ctl_s,
    input  logic       rw_s,
    output logic       eff,
    output logic       start,
    output ctl_e       acc_ctl,
    output logic       acc_rw
);
    logic       eff_q, as_q, as_fall, lat_vld, lat_rw;
    logic [1:0] lat_ctl;

    assign eff     = !cs_n_s && !ds_n_s;
    assign start   = eff && !eff_q;
    assign as_fall = as_q && !as_n_s;

    // Delay the strobe and address strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_q <= 1'b0;
            as_q  <= 1'b1;
        end else begin
            eff_q <= eff;
            as_q  <= as_n_s;
        end
    end

    // Latch control and direction on an address-strobe fall; consume at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_vld <= 1'b0;
            lat_ctl <= 2'b00;
            lat_rw  <= 1'b1;
        end else if (as_fall) begin
            lat_vld <= 1'b1;
            lat_ctl <= ctl_s;
            lat_rw  <= rw_s;
        end else if (start) begin
            lat_vld <= 1'b0;
        end
    end

    // Choose the control for this access.
    always_comb begin
        if (lat_vld && !as_fall) begin
            acc_ctl = ctl_e'(lat_ctl);
            acc_rw  = lat_rw;
        end else begin
            acc_ctl = ctl_e'(ctl_s);
            acc_rw  = rw_s;
        end
    end
endmodule

// File: rtl/hpi_core.sv
// Access engine: register accesses, memory transfers, pointer rules, ready.
// Assumes: memory read data is valid one cycle after the request cycle; the
// host keeps the strobe active until ready returns high.
module hpi_core
    import hpi_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eff,
    input  logic              start,
    input  ctl_e              acc_ctl,
    input  logic              acc_rw,
    input  logic [BE_W-1:0]   be_n,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              host_rdy,
    output logic [DATA_W-1:0] dout,
    output logic              oe,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [DATA_W-1:0] mem_wdata
);
    state_e            state;
    ctl_e              cur_ctl;
    logic [DATA_W-1:0] base, ptr;
    logic              swap, cur_rd, cur_inc;

    // Reverse byte order of a data word.
    function automatic logic [DATA_W-1:0] bswap(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < BE_W; b++) r[8*b +: 8] = v[8*(BE_W-1-b) +: 8];
        return r;
    endfunction

    // Reverse lane-enable order to follow the byte swap.
    function automatic logic [BE_W-1:0] lswap(input logic [BE_W-1:0] v);
        logic [BE_W-1:0] r;
        for (int b = 0; b < BE_W; b++) r[b] = v[BE_W-1-b];
        return r;
    endfunction

    assign oe = eff && cur_rd && (state == ST_HOLD);

    // Main sequencer: one transfer per start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_ctl   <= CTL_CFG;
            host_rdy  <= 1'b1;
            base      <= '0;
            ptr       <= '0;
            swap      <= 1'b0;
            cur_rd    <= 1'b0;
            cur_inc   <= 1'b0;
            dout      <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cur_rd  <= acc_rw;
                    cur_ctl <= acc_ctl;
                    case (acc_ctl)
                        CTL_CFG: begin
                            if (acc_rw) dout <= {{(DATA_W-1){1'b0}}, swap};
                            else        swap <= din[0];
                            state <= ST_HOLD;
                        end
                        CTL_ADDR: begin
                            if (acc_rw) dout <= base;
                            else begin
                                base <= din;
                                ptr  <= din;
                            end
                            state <= ST_HOLD;
                        end
                        default: begin
                            mem_req   <= 1'b1;
                            mem_we    <= !acc_rw;
                            mem_addr  <= ptr;
                            mem_wdata <= swap ? bswap(din) : din;
                            mem_be    <= swap ? lswap(~be_n) : ~be_n;
                            cur_inc   <= (acc_ctl == CTL_AUTO) && !be_n[BE_W-1];
                            host_rdy  <= 1'b0;
                            state     <= ST_ISSUE;
                        end
                    endcase
                end
                ST_ISSUE: begin
                    mem_req <= 1'b0;
                    state   <= ST_CAPT;
                end
                ST_CAPT: begin
                    if (cur_rd) dout <= swap ? bswap(mem_rdata) : mem_rdata;
                    if (cur_inc) ptr <= ptr + 1'b1;
                    host_rdy <= 1'b1;
                    state    <= ST_HOLD;
                end
                default: if (!eff) state <= ST_IDLE;
            endcase
        end
    end

    // R1
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R6
    busy_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !host_rdy);
    // R4
    base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && acc_ctl == CTL_AUTO) |=> $stable(base));
    // R2
    fixed_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPT && cur_ctl == CTL_FIXED) |=> $stable(ptr));
endmodule

// File: rtl/hostport_bridge.sv
// Top of the multiplexed host port bridge: synchronisers, strobe unit, core.
// Assumes: the host holds control, byte enables and write data stable from
// before the strobe until ready returns; memory answers reads in one cycle.
module hostport_bridge
    import hpi_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int BE_W  = DATA_W / 8,
    localparam int SYNC_W = 6 + BE_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_n,
    input  logic              host_ds_n,
    input  logic              host_as_n,
    input  logic              host_rw,
    input  logic [1:0]        host_ctl,
    input  logic [BE_W-1:0]   host_be_n,
    input  logic [DATA_W-1:0] host_d_in,
    output logic [DATA_W-1:0] host_d_out,
    output logic              host_d_oe,
    output logic              host_rdy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [BE_W-1:0]   mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [SYNC_W-1:0] raw, syn;
    logic              cs_n_s, ds_n_s, as_n_s, rw_s;
    logic [1:0]        ctl_s;
    logic [BE_W-1:0]   be_n_s;
    logic [DATA_W-1:0] din_s;
    logic              eff, start, acc_rw;
    ctl_e              acc_ctl;

    assign raw = {host_cs_n, host_ds_n, host_as_n, host_rw, host_ctl, host_be_n, host_d_in};
    assign {cs_n_s, ds_n_s, as_n_s, rw_s, ctl_s, be_n_s, din_s} = syn;

    hpi_sync #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    hpi_strobe u_strobe (
        .clk(clk), .rst_n(rst_n),
        .cs_n_s(cs_n_s), .ds_n_s(ds_n_s), .as_n_s(as_n_s),
        .ctl_s(ctl_s), .rw_s(rw_s),
        .eff(eff), .start(start), .acc_ctl(acc_ctl), .acc_rw(acc_rw)
    );

    hpi_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .eff(eff), .start(start),
        .acc_ctl(acc_ctl), .acc_rw(acc_rw), .be_n(be_n_s), .din(din_s),
        .mem_rdata(mem_rdata), .host_rdy(host_rdy), .dout(host_d_out),
        .oe(host_d_oe), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
    );
endmodule

// File: tb/tb_hostport_bridge.sv
module tb_hostport_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1, host_ds_n = 1'b1, host_as_n = 1'b1, host_rw = 1'b1;
    logic [1:0]  host_ctl = 2'b11, host_be_n = 2'b11;
    logic [15:0] host_d_in = '0, host_d_out, mem_addr, mem_wdata, mem_rdata;
    logic        host_d_oe, host_rdy, mem_req, mem_we;
    logic [1:0]  mem_be;

    always #4 clk = !clk;

    hostport_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_ds_n(host_ds_n),
        .host_as_n(host_as_n), .host_rw(host_rw), .host_ctl(host_ctl),
        .host_be_n(host_be_n), .host_d_in(host_d_in), .host_d_out(host_d_out),
        .host_d_oe(host_d_oe), .host_rdy(host_rdy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory stub on the synchronous port.
    logic [15:0] stub_mem [256];
    initial begin
        for (int i = 0; i < 256; i++) stub_mem[i] = '0;
        mem_rdata = '0;
    end
    always @(posedge clk) if (mem_req) begin
        if (mem_we) begin
            if (mem_be[0]) stub_mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) stub_mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
        end else mem_rdata <= stub_mem[mem_addr[7:0]];
    end

    // Reference model state.
    int          checks = 0, errors = 0;
    int          req_cnt = 0;
    bit          saw_busy = 0, allow_oe = 0, ds_tied = 0;
    logic [15:0] exp_rd = '0;
    logic [15:0] m_mem [256];
    logic [15:0] m_base = '0, m_ptr = '0;
    bit          m_swap = 0;
    initial for (int i = 0; i < 256; i++) m_mem[i] = '0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Per-clock comparison of the output enable and read bus against the model.
    always @(posedge clk) begin
        if (mem_req) req_cnt++;
        if (!host_rdy) saw_busy = 1;
        #2;
        if (rst_n && host_d_oe && !allow_oe) check(0, "R7 oe outside read strobe", host_d_oe, 0);
        if (rst_n && host_d_oe && allow_oe && host_d_out !== exp_rd)
            check(0, "R7 read bus", host_d_out, exp_rd);
    end

    // One host access with model update; pctl/prw are the pins after the address strobe.
    task automatic access(input bit use_as, input logic [1:0] ctl, input bit rd,
                          input logic [1:0] ben, input logic [15:0] wd,
                          input logic [1:0] pctl, input bit prd, input string tag);
        bit          data_acc = ctl[0];
        logic [7:0]  a = m_ptr[7:0];
        logic [15:0] mw;
        logic [1:0]  mbe;
        // Model.
        case (ctl)
            2'b00: if (rd) exp_rd = {15'b0, m_swap}; else m_swap = wd[0];
            2'b10: if (rd) exp_rd = m_base; else begin m_base = wd; m_ptr = wd; end
            default: begin
                if (rd) exp_rd = m_swap ? {m_mem[a][7:0], m_mem[a][15:8]} : m_mem[a];
                else begin
                    mw  = m_swap ? {wd[7:0], wd[15:8]} : wd;
                    mbe = m_swap ? {!ben[0], !ben[1]} : {!ben[1], !ben[0]};
                    if (mbe[0]) m_mem[a][7:0]  = mw[7:0];
                    if (mbe[1]) m_mem[a][15:8] = mw[15:8];
                end
                if (ctl == 2'b01 && !ben[1]) m_ptr = m_ptr + 1;
            end
        endcase
        // Drive.
        @(negedge clk);
        host_ctl = ctl; host_rw = rd; host_be_n = ben; host_d_in = wd;
        if (use_as) begin
            host_as_n = 0;
            repeat (3) @(negedge clk);
            host_ctl = pctl; host_rw = prd;
        end
        repeat (2) @(negedge clk);
        req_cnt = 0; saw_busy = 0; allow_oe = rd;
        host_cs_n = 0;
        if (!ds_tied) host_ds_n = 0;
        repeat (9) @(negedge clk);
        check(host_rdy == 1, {tag, " R6 ready after transfer"}, host_rdy, 1);
        if (data_acc) begin
            check(saw_busy == 1, {tag, " R6 busy seen"}, saw_busy, 1);
            check(req_cnt == 1, {tag, " R1 one request"}, req_cnt, 1);
        end else check(req_cnt == 0, {tag, " R1 no request"}, req_cnt, 0);
        if (rd) begin
            check(host_d_oe == 1, {tag, " R7 oe on read"}, host_d_oe, 1);
            check(host_d_out == exp_rd, {tag, " read data"}, host_d_out, exp_rd);
        end else check(host_d_oe == 0, {tag, " R7 oe off on write"}, host_d_oe, 0);
        host_cs_n = 1;
        if (!ds_tied) host_ds_n = 1;
        host_as_n = 1;
        repeat (5) @(negedge clk);
        check(host_d_oe == 0, {tag, " R7 oe off after strobe"}, host_d_oe, 0);
        allow_oe = 0;
    endtask

    task automatic acc(input logic [1:0] ctl, input bit rd, input logic [1:0] ben,
                       input logic [15:0] wd, input string tag);
        access(0, ctl, rd, ben, wd, ctl, rd, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check(host_rdy == 1, "R10 rdy after reset", host_rdy, 1);
        check(host_d_oe == 0, "R10 oe after reset", host_d_oe, 0);
        check(mem_req == 0, "R10 no request after reset", mem_req, 0);
        acc(2'b10, 1, 2'b00, 16'h0, "R10 base zero");
        acc(2'b00, 1, 2'b00, 16'h0, "R10 swap clear");
        // R8 address register
        acc(2'b10, 0, 2'b00, 16'h0010, "R8 addr write");
        acc(2'b10, 1, 2'b00, 16'h0, "R8 addr read");
        check(exp_rd == 16'h0010, "R8 model base", exp_rd, 16'h0010);
        // R3 auto-increment writes to n, n+1, n+2
        acc(2'b01, 0, 2'b00, 16'h1111, "R3 auto wr0");
        acc(2'b01, 0, 2'b00, 16'h2222, "R3 auto wr1");
        acc(2'b01, 0, 2'b00, 16'h3333, "R3 auto wr2");
        check(stub_mem[8'h12] == 16'h3333, "R3 word at n+2", stub_mem[8'h12], 16'h3333);
        // R4 address readback returns base
        acc(2'b10, 1, 2'b00, 16'h0, "R4 base after auto");
        // R2 fixed reads do not move
        acc(2'b10, 0, 2'b00, 16'h0011, "R2 addr");
        acc(2'b11, 1, 2'b00, 16'h0, "R2 fixed rd0");
        acc(2'b11, 1, 2'b00, 16'h0, "R2 fixed rd1");
        acc(2'b01, 1, 2'b00, 16'h0, "R3 auto rd0");
        acc(2'b01, 1, 2'b00, 16'h0, "R3 auto rd1");
        // R5 byte lanes and increment rule
        acc(2'b10, 0, 2'b00, 16'h0020, "R5 addr");
        acc(2'b01, 0, 2'b10, 16'h00AA, "R5 low byte");
        acc(2'b01, 0, 2'b01, 16'hBB00, "R5 high byte");
        acc(2'b01, 0, 2'b00, 16'h5555, "R5 next word");
        check(stub_mem[8'h20] == 16'hBBAA, "R5 merged word", stub_mem[8'h20], 16'hBBAA);
        check(stub_mem[8'h21] == 16'h5555, "R5 advance after high", stub_mem[8'h21], 16'h5555);
        acc(2'b10, 0, 2'b00, 16'h0020, "R5 addr again");
        acc(2'b11, 1, 2'b00, 16'h0, "R5 readback");
        // R8 byte swap
        acc(2'b00, 0, 2'b00, 16'h0001, "R8 swap on");
        acc(2'b00, 1, 2'b00, 16'h0, "R8 swap read");
        acc(2'b10, 0, 2'b00, 16'h0030, "R8 addr");
        acc(2'b11, 0, 2'b00, 16'h1234, "R8 swapped write");
        check(stub_mem[8'h30] == 16'h3412, "R8 swapped memory", stub_mem[8'h30], 16'h3412);
        acc(2'b11, 1, 2'b00, 16'h0, "R8 swapped read");
        acc(2'b00, 0, 2'b00, 16'h0000, "R8 swap off");
        acc(2'b11, 1, 2'b00, 16'h0, "R8 raw read");
        // R9 address strobe latch: latched auto write, pins then show fixed read
        acc(2'b10, 0, 2'b00, 16'h0040, "R9 addr");
        access(1, 2'b01, 0, 2'b00, 16'hCAFE, 2'b11, 1, "R9 latched");
        check(stub_mem[8'h40] == 16'hCAFE, "R9 latched write", stub_mem[8'h40], 16'hCAFE);
        acc(2'b11, 0, 2'b00, 16'hBEEF, "R9 pointer moved");
        check(stub_mem[8'h41] == 16'hBEEF, "R9 increment applied", stub_mem[8'h41], 16'hBEEF);
        // R1 data strobe tied active, chip select frames
        ds_tied = 1;
        @(negedge clk); host_ds_n = 0;
        acc(2'b01, 0, 2'b00, 16'h7777, "R1 cs only wr");
        acc(2'b10, 0, 2'b00, 16'h0041, "R1 cs only addr");
        acc(2'b01, 1, 2'b00, 16'h0, "R1 cs only rd0");
        acc(2'b01, 1, 2'b00, 16'h0, "R1 cs only rd1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule